// File: doc/BRIEF.md
# Paged Memory Mapper with Display-Bank Write Shadowing

This block sits between a processor with a 24-bit address bus and the memories of a home computer. Every access is decoded at a granularity of 256-byte pages. Each page resolves to a region number, and each region holds a storage kind (none, RAM or ROM), four attribute flags and an offset. The block adds the offset to the incoming address to form the physical RAM or ROM address, or it routes the access to an I/O select when the region is flagged for I/O. Region 0 always behaves as a hole: reads from it return 0xFF and writes to it are dropped.

A write to a RAM region flagged for shadowing is performed twice. The first write goes to the primary location. The second goes, on the next cycle, to the same 16-bit offset in display bank $E0 or $E1, which occupy the top 128 KiB of RAM. Each access reports a cost in master-clock cycles: 5 for a fast access, and 14 for a slow-bus region or a shadowed write. Two running phase counters, modulo 5 and modulo 14, accumulate these costs.

Requests enter on a valid/ready channel and results leave on a valid/ready channel. The block handles one transaction at a time. `req_ready` is high only when the block is idle and no configuration write is in progress. The response is held stable, without change, for as long as `rsp_valid` is high and `rsp_ready` is low. The lookup tables are loaded through a one-cycle synchronous configuration port.

Top module: `page_mapper`

## Requirements
- R1: Decode is two-level. The bank table, indexed by address bits 23:16, gives a class. The page table, indexed by class*256 + address bits 15:8, gives a region number. `cfg_tbl` selects the table for a configuration write: 0 for the bank table, 1 for the page table, 2 for the region table. All tables reset to zero.
- R2: With default parameters, a region word holds the offset in bits 17:0, the flags in bits 21:18 and the kind in bits 23:22. Kind 0 is none, 1 is RAM and 2 is ROM. For a RAM region, `ram_addr` = (address + offset) mod RAM size, and writes store `req_wdata` there.
- R3: Region number 0 is unmapped whatever the region table holds at index 0. Reads from it return 0xFF, and writes to it cause no memory or I/O strobe.
- R4: For a ROM region, reads use `rom_addr` = (address + offset) mod ROM size. Writes to a ROM region strobe nothing.
- R5: Flag bit 0 mirrors writes to bank $E0, and flag bit 1 mirrors writes to bank $E1; bit 0 wins if both are set. The mirror is issued only after a primary RAM write. It follows that write on the very next cycle, at address (RAM size − 128 KiB) + bank*64 KiB + address bits 15:0.
- R6: `rsp_cycles` is 14 when flag bit 2 (slow bus) is set, or when the access is a write and flag bit 0 or bit 1 is set. Otherwise it is 5.
- R7: On each accepted request, `phase_fast` advances by the cost modulo 5 and `phase_slow` advances by the cost modulo 14.
- R8: Flag bit 3 (I/O) raises `io_sel` with `io_addr` = address bits 15:0 and `io_we` for writes. No RAM or ROM enable is raised, and read data comes from `io_rdata`.
- R9: While `cfg_we` is high, `req_ready` is low.
- R10: `busy` is high from acceptance until the response is taken, and `req_ready` is low while `busy` is high.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_cycles` hold steady.
- R12: After reset the block is idle: `req_ready` is high, `busy`, `rsp_valid` and all strobes are low, and both phase counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tbl | input | 2 | Table select: 0 bank, 1 page, 2 region |
| cfg_idx | input | 10 | Table index |
| cfg_data | input | 24 | Table entry value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Processor address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with valid |
| rsp_rdata | output | 8 | Read data (0xFF for unmapped) |
| rsp_cycles | output | 4 | Access cost in master-clock cycles |
| busy | output | 1 | Transaction in progress |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 18 | RAM physical address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid in the cycle of `ram_en` |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | 17 | ROM physical address |
| rom_rdata | input | 8 | ROM read data, valid in the cycle of `rom_en` |
| io_sel | output | 1 | I/O select strobe |
| io_we | output | 1 | I/O write |
| io_addr | output | 16 | I/O offset (low address bits) |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data, valid in the cycle of `io_sel` |
| phase_fast | output | 3 | Running cost phase modulo 5 |
| phase_slow | output | 4 | Running cost phase modulo 14 |

## Verification
The assertions assume three things about the inputs. Memory and I/O read data arrive combinationally in the cycle of the matching enable. Reset is applied before the first transaction. No primary RAM write lands in the display banks on the cycle straight after another write. The last holds because transactions are serialised, so two consecutive write strobes can only be a primary write followed by its mirror. The bench keeps to these assumptions. It models RAM, ROM and I/O as combinational responders, changes requests and configuration only at falling edges, never raises `cfg_we` in the middle of a transaction, and withholds `rsp_ready` only in the scenario that tests response hold.

// File: rtl/pmm_pkg.sv
package pmm_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_RAM  = 2'd1,
    KIND_ROM  = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_MIRROR,
    ST_RESP
  } mst_e;

  // attribute flag positions
  localparam int FLG_E0   = 0;
  localparam int FLG_E1   = 1;
  localparam int FLG_SLOW = 2;
  localparam int FLG_IO   = 3;

  // configuration table selects
  localparam logic [1:0] TBL_BANK   = 2'd0;
  localparam logic [1:0] TBL_PAGE   = 2'd1;
  localparam logic [1:0] TBL_REGION = 2'd2;

  localparam logic [3:0] COST_FAST = 4'd5;
  localparam logic [3:0] COST_SLOW = 4'd14;

endpackage

// File: rtl/pmm_tables.sv
module pmm_tables
  import pmm_pkg::*;
#(
  parameter int CLS_W = 2,
  parameter int REG_W = 5,
  parameter int OFS_W = 18,
  localparam int IDX_W = CLS_W + 8,
  localparam int CFG_W = OFS_W + 6,
  localparam int NCLS  = 1 << CLS_W,
  localparam int NREG  = 1 << REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_tbl,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic [15:0]      lk_page,
  output kind_e            lk_kind,
  output logic [3:0]       lk_flags,
  output logic [OFS_W-1:0] lk_ofs
);

  logic [CLS_W-1:0] bank_cls [256];
  logic [REG_W-1:0] page_reg [NCLS*256];
  logic [1:0]       rg_kind  [NREG];
  logic [3:0]       rg_flags [NREG];
  logic [OFS_W-1:0] rg_ofs   [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 256; b++) bank_cls[b] <= '0;
      for (int p = 0; p < NCLS*256; p++) page_reg[p] <= '0;
      for (int r = 0; r < NREG; r++) begin
        rg_kind[r]  <= '0;
        rg_flags[r] <= '0;
        rg_ofs[r]   <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_tbl)
        TBL_BANK:   bank_cls[cfg_idx[7:0]] <= cfg_data[CLS_W-1:0];
        TBL_PAGE:   page_reg[cfg_idx] <= cfg_data[REG_W-1:0];
        TBL_REGION: begin
          rg_ofs[cfg_idx[REG_W-1:0]]   <= cfg_data[OFS_W-1:0];
          rg_flags[cfg_idx[REG_W-1:0]] <= cfg_data[OFS_W+3:OFS_W];
          rg_kind[cfg_idx[REG_W-1:0]]  <= cfg_data[OFS_W+5:OFS_W+4];
        end
        default: ;
      endcase
    end
  end

  logic [CLS_W-1:0] cls;
  logic [REG_W-1:0] rnum;

  always_comb begin
    cls  = bank_cls[lk_page[15:8]];
    rnum = page_reg[{cls, lk_page[7:0]}];
    if (rnum == '0) begin
      // the hole: never mapped, whatever entry 0 holds
      lk_kind  = KIND_NONE;
      lk_flags = '0;
      lk_ofs   = '0;
    end else begin
      lk_kind  = kind_e'(rg_kind[rnum]);
      lk_flags = rg_flags[rnum];
      lk_ofs   = rg_ofs[rnum];
    end
  end

endmodule

// File: rtl/pmm_cost.sv
module pmm_cost
  import pmm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       slow,
  output logic [3:0] cost,
  output logic [2:0] phase_fast,
  output logic [3:0] phase_slow
);

  localparam logic [4:0] MOD_FAST = 5'd5;
  localparam logic [4:0] MOD_SLOW = 5'd14;

  logic [4:0] sum_f, sum_s, nxt_f, nxt_s;

  always_comb begin
    cost  = slow ? COST_SLOW : COST_FAST;
    sum_f = {2'b00, phase_fast} + {1'b0, cost};
    sum_s = {1'b0, phase_slow} + {1'b0, cost};
    nxt_f = sum_f % MOD_FAST;
    nxt_s = sum_s % MOD_SLOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_fast <= '0;
      phase_slow <= '0;
    end else if (fire) begin
      phase_fast <= nxt_f[2:0];
      phase_slow <= nxt_s[3:0];
    end
  end

endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import pmm_pkg::*;
#(
  parameter int RAM_KB = 256,
  parameter int ROM_KB = 128,
  parameter int CLS_W  = 2,
  parameter int REG_W  = 5,
  localparam int RAM_AW    = $clog2(RAM_KB * 1024),
  localparam int ROM_AW    = $clog2(ROM_KB * 1024),
  localparam int OFS_W     = (RAM_AW > ROM_AW) ? RAM_AW : ROM_AW,
  localparam int IDX_W     = CLS_W + 8,
  localparam int CFG_W     = OFS_W + 6,
  localparam int SLOW_BASE = (RAM_KB - 128) * 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_tbl,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [23:0]       req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_rdata,
  output logic [3:0]        rsp_cycles,
  output logic              busy,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              rom_en,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_rdata,
  output logic              io_sel,
  output logic              io_we,
  output logic [15:0]       io_addr,
  output logic [7:0]        io_wdata,
  input  logic [7:0]        io_rdata,
  output logic [2:0]        phase_fast,
  output logic [3:0]        phase_slow
);

  kind_e            lk_kind;
  logic [3:0]       lk_flags;
  logic [OFS_W-1:0] lk_ofs;
  logic [OFS_W-1:0] lk_phys;
  logic [3:0]       cost;
  logic             acc, slow_cost;

  pmm_tables #(.CLS_W(CLS_W), .REG_W(REG_W), .OFS_W(OFS_W)) u_tables (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_tbl  (cfg_tbl),
    .cfg_idx  (cfg_idx),
    .cfg_data (cfg_data),
    .lk_page  (req_addr[23:8]),
    .lk_kind  (lk_kind),
    .lk_flags (lk_flags),
    .lk_ofs   (lk_ofs)
  );

  pmm_cost u_cost (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (acc),
    .slow       (slow_cost),
    .cost       (cost),
    .phase_fast (phase_fast),
    .phase_slow (phase_slow)
  );

  mst_e             st;
  logic             q_write, q_io, q_shadow, q_e1sel;
  logic [15:0]      q_lo16;
  logic [7:0]       q_wdata, r_rdata, rd_mux;
  kind_e            q_kind;
  logic [OFS_W-1:0] q_phys;
  logic [3:0]       q_cost;
  logic             iss, mir, iss_ram, need_mirror;
  logic [RAM_AW-1:0] mir_addr;

  assign req_ready = (st == ST_IDLE) && !cfg_we;
  assign acc       = req_valid && req_ready;
  assign lk_phys   = req_addr[OFS_W-1:0] + lk_ofs;
  assign slow_cost = lk_flags[FLG_SLOW] ||
                     (req_write && (lk_flags[FLG_E0] || lk_flags[FLG_E1]));

  // strobes come from the captured transaction only
  assign iss         = (st == ST_ISSUE);
  assign mir         = (st == ST_MIRROR);
  assign iss_ram     = iss && !q_io && (q_kind == KIND_RAM);
  assign need_mirror = q_write && q_shadow && !q_io && (q_kind == KIND_RAM);
  assign mir_addr    = RAM_AW'(SLOW_BASE) + RAM_AW'({q_e1sel, q_lo16});

  assign ram_en    = iss_ram || mir;
  assign ram_we    = (iss_ram && q_write) || mir;
  assign ram_addr  = mir ? mir_addr : q_phys[RAM_AW-1:0];
  assign ram_wdata = q_wdata;
  assign rom_en    = iss && !q_io && (q_kind == KIND_ROM) && !q_write;
  assign rom_addr  = q_phys[ROM_AW-1:0];
  assign io_sel    = iss && q_io;
  assign io_we     = iss && q_io && q_write;
  assign io_addr   = q_lo16;
  assign io_wdata  = q_wdata;

  always_comb begin
    if (q_io)                    rd_mux = io_rdata;
    else if (q_kind == KIND_RAM) rd_mux = ram_rdata;
    else if (q_kind == KIND_ROM) rd_mux = rom_rdata;
    else                         rd_mux = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      q_write  <= 1'b0;
      q_io     <= 1'b0;
      q_shadow <= 1'b0;
      q_e1sel  <= 1'b0;
      q_lo16   <= '0;
      q_wdata  <= '0;
      q_kind   <= KIND_NONE;
      q_phys   <= '0;
      q_cost   <= '0;
      r_rdata  <= 8'hFF;
    end else begin
      case (st)
        ST_IDLE: if (acc) begin
          st       <= ST_ISSUE;
          q_write  <= req_write;
          q_lo16   <= req_addr[15:0];
          q_wdata  <= req_wdata;
          q_kind   <= lk_kind;
          q_io     <= lk_flags[FLG_IO];
          q_shadow <= lk_flags[FLG_E0] | lk_flags[FLG_E1];
          q_e1sel  <= !lk_flags[FLG_E0];
          q_phys   <= lk_phys;
          q_cost   <= cost;
        end
        ST_ISSUE: begin
          r_rdata <= rd_mux;
          st      <= need_mirror ? ST_MIRROR : ST_RESP;
        end
        ST_MIRROR: st <= ST_RESP;
        ST_RESP:   if (rsp_ready) st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st != ST_IDLE);
  assign rsp_valid  = (st == ST_RESP);
  assign rsp_rdata  = r_rdata;
  assign rsp_cycles = q_cost;

endmodule

// File: rtl/pmm_checks.sv
module pmm_checks #(
  parameter int RAM_AW    = 18,
  parameter int SLOW_BASE = 131072
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              req_ready,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_rdata,
  input logic [3:0]        rsp_cycles,
  input logic              ram_en,
  input logic              ram_we,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              rom_en,
  input logic              io_sel,
  input logic [2:0]        phase_fast,
  input logic [3:0]        phase_slow
);

  assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_en, rom_en, io_sel}));

  assert_cfg_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !req_ready);

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_cycles)));

  assert_cost_values_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cycles == 4'd5 || rsp_cycles == 4'd14));

  assert_phase_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_fast < 3'd5) && (phase_slow < 4'd14));

  // back-to-back writes only happen as primary + mirror
  assert_mirror_in_display_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_we && $past(ram_en && ram_we)) |-> (ram_addr >= RAM_AW'(SLOW_BASE)));

endmodule

bind page_mapper pmm_checks #(.RAM_AW(RAM_AW), .SLOW_BASE(SLOW_BASE)) u_pmm_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .req_ready  (req_ready),
  .busy       (busy),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .rsp_cycles (rsp_cycles),
  .ram_en     (ram_en),
  .ram_we     (ram_we),
  .ram_addr   (ram_addr),
  .rom_en     (rom_en),
  .io_sel     (io_sel),
  .phase_fast (phase_fast),
  .phase_slow (phase_slow)
);

// File: tb/test_page_mapper.sv
module test_page_mapper;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 0;
  logic [1:0]  cfg_tbl = 0;
  logic [9:0]  cfg_idx = 0;
  logic [23:0] cfg_data = 0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [23:0] req_addr = 0;
  logic [7:0]  req_wdata = 0;
  logic        req_ready, rsp_valid, busy;
  logic [7:0]  rsp_rdata;
  logic [3:0]  rsp_cycles;
  logic        ram_en, ram_we, rom_en, io_sel, io_we;
  logic [17:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata, rom_rdata, io_wdata, io_rdata;
  logic [16:0] rom_addr;
  logic [15:0] io_addr;
  logic [2:0]  phase_fast;
  logic [3:0]  phase_slow;

  page_mapper i_page_mapper (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_cycles(rsp_cycles), .busy(busy),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .io_sel(io_sel), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata),
    .phase_fast(phase_fast), .phase_slow(phase_slow)
  );

  // ---- memory and I/O responders ----
  logic [7:0] mem [0:4095];
  function automatic int midx(input logic [17:0] a);
    return int'({a[17:16], a[9:0]});
  endfunction

  assign ram_rdata = mem[midx(ram_addr)];
  assign rom_rdata = rom_addr[7:0] ^ rom_addr[16:9];
  assign io_rdata  = io_addr[7:0] + 8'd1;

  int          wr_cnt = 0, ram_cnt = 0, rom_cnt = 0;
  logic [17:0] last_wr = 0, prev_wr = 0;
  logic [15:0] io_last_addr = 0;
  logic [7:0]  io_last_data = 0;

  always @(posedge clk) begin
    if (ram_en) ram_cnt <= ram_cnt + 1;
    if (rom_en) rom_cnt <= rom_cnt + 1;
    if (ram_en && ram_we) begin
      mem[midx(ram_addr)] <= ram_wdata;
      wr_cnt  <= wr_cnt + 1;
      prev_wr <= last_wr;
      last_wr <= ram_addr;
    end
    if (io_sel && io_we) begin
      io_last_addr <= io_addr;
      io_last_data <= io_wdata;
    end
  end

  // ---- bookkeeping ----
  int n_chk = 0, n_err = 0;
  int exp_pf = 0, exp_ps = 0;
  bit done = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [23:0] rgn(input logic [1:0] kind, input logic [3:0] flg,
                                      input logic [17:0] ofs);
    return {kind, flg, ofs};
  endfunction

  task automatic cfg_write(input logic [1:0] tbl, input int idx, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_tbl = tbl; cfg_idx = idx[9:0]; cfg_data = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic access(input logic w, input logic [23:0] a, input logic [7:0] d,
                        input int exp_cost, input string tag, output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    chk({tag, " R6 cost"}, 32'(rsp_cycles), 32'(exp_cost));
    exp_pf = (exp_pf + exp_cost) % 5;
    exp_ps = (exp_ps + exp_cost) % 14;
    @(posedge clk); #1;
  endtask

  // ---- scenarios ----
  task automatic t_reset;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R12 req_ready", 32'(req_ready), 1);
    chk("R12 busy", 32'(busy), 0);
    chk("R12 rsp_valid", 32'(rsp_valid), 0);
    chk("R12 strobes", 32'({ram_en, rom_en, io_sel}), 0);
    chk("R12 phases", 32'({phase_fast, phase_slow}), 0);
  endtask

  task automatic t_unmapped;
    logic [7:0] rd;
    int w0;
    // before any configuration every page is region 0
    access(0, 24'h001234, 0, 5, "R3 unmapped read", rd);
    chk("R3 unmapped read data", 32'(rd), 32'hFF);
    w0 = wr_cnt;
    access(1, 24'h001234, 8'h55, 5, "R3 unmapped write", rd);
    chk("R3 unmapped write strobes", 32'(wr_cnt), 32'(w0));
  endtask

  task automatic t_configure;
    // regions
    cfg_write(2, 1, rgn(2'd1, 4'h0, 18'h0));
    cfg_write(2, 2, rgn(2'd1, 4'h2, 18'h0));
    cfg_write(2, 3, rgn(2'd1, 4'h1, 18'h0));
    cfg_write(2, 4, rgn(2'd0, 4'h8, 18'h0));
    cfg_write(2, 5, rgn(2'd1, 4'h4, 18'h0));
    cfg_write(2, 6, rgn(2'd1, 4'h0, 18'h20000));
    cfg_write(2, 8, rgn(2'd2, 4'h0, 18'h0));
    cfg_write(2, 9, rgn(2'd1, 4'h3, 18'h0));
    // banks -> classes
    cfg_write(0, 8'hE0, 24'd1);
    cfg_write(0, 8'hE1, 24'd1);
    cfg_write(0, 8'hFE, 24'd2);
    cfg_write(0, 8'hFF, 24'd2);
    cfg_write(0, 8'h80, 24'd3);
    // class 0 pages
    cfg_write(1, 8'h01, 24'd1);
    cfg_write(1, 8'h20, 24'd2);
    cfg_write(1, 8'h04, 24'd3);
    cfg_write(1, 8'hC0, 24'd4);
    cfg_write(1, 8'h30, 24'd5);
    cfg_write(1, 8'h05, 24'd9);
    // class 1 (display banks) pages
    cfg_write(1, 256 + 8'h20, 24'd6);
    cfg_write(1, 256 + 8'h04, 24'd6);
    cfg_write(1, 256 + 8'h05, 24'd6);
    // class 2 (ROM banks) page 0
    cfg_write(1, 512, 24'd8);
  endtask

  task automatic t_ram_basic;
    logic [7:0] rd;
    int w0;
    w0 = wr_cnt;
    access(1, 24'h000123, 8'hA7, 5, "R2 ram write", rd);
    chk("R2 one write", 32'(wr_cnt), 32'(w0 + 1));
    chk("R2 write address", 32'(last_wr), 32'h00123);
    access(0, 24'h000123, 0, 5, "R1 ram read", rd);
    chk("R1 lookup read data", 32'(rd), 32'hA7);
  endtask

  task automatic t_hole;
    logic [7:0] rd;
    // bank $80 uses class 3 whose pages are all region 0
    access(0, 24'h801234, 0, 5, "R1 class 3 read", rd);
    chk("R1 class 3 unmapped", 32'(rd), 32'hFF);
    cfg_write(2, 0, rgn(2'd1, 4'h0, 18'h0));
    access(0, 24'h801234, 0, 5, "R3 entry 0 loaded", rd);
    chk("R3 region 0 still a hole", 32'(rd), 32'hFF);
  endtask

  task automatic t_rom;
    logic [7:0] rd;
    int w0, r0;
    access(0, 24'hFE0042, 0, 5, "R4 rom read low", rd);
    chk("R4 rom bank FE data", 32'(rd), 32'h42);
    access(0, 24'hFF0042, 0, 5, "R4 rom read high", rd);
    chk("R4 rom bank FF data", 32'(rd), 32'hC2);
    w0 = wr_cnt; r0 = rom_cnt;
    access(1, 24'hFE0042, 8'h99, 5, "R4 rom write", rd);
    chk("R4 rom write no ram strobe", 32'(wr_cnt), 32'(w0));
    chk("R4 rom write no rom strobe", 32'(rom_cnt), 32'(r0));
  endtask

  task automatic t_shadow;
    logic [7:0] rd;
    int w0;
    w0 = wr_cnt;
    access(1, 24'h002034, 8'h3C, 14, "R5 shadow E1 write", rd);
    chk("R5 two writes E1", 32'(wr_cnt), 32'(w0 + 2));
    chk("R5 primary addr E1", 32'(prev_wr), 32'h02034);
    chk("R5 mirror addr E1", 32'(last_wr), 32'h32034);
    access(0, 24'hE12034, 0, 5, "R2 display read E1", rd);
    chk("R5 mirrored data E1", 32'(rd), 32'h3C);
    access(1, 24'h000456, 8'h5D, 14, "R5 shadow E0 write", rd);
    chk("R5 mirror addr E0", 32'(last_wr), 32'h20456);
    access(0, 24'hE00456, 0, 5, "R2 display read E0", rd);
    chk("R5 mirrored data E0", 32'(rd), 32'h5D);
    access(1, 24'h000580, 8'h77, 14, "R5 both flags write", rd);
    chk("R5 both flags pick E0", 32'(last_wr), 32'h20580);
    access(0, 24'h000580, 0, 5, "R5 shadowed read", rd);
    chk("R6 shadowed read stays fast", 32'(rd), 32'h77);
  endtask

  task automatic t_slow;
    logic [7:0] rd;
    int w0;
    access(0, 24'h003000, 0, 14, "R6 slow read", rd);
    w0 = wr_cnt;
    access(1, 24'h003000, 8'h11, 14, "R6 slow write", rd);
    chk("R6 slow write single strobe", 32'(wr_cnt), 32'(w0 + 1));
  endtask

  task automatic t_io;
    logic [7:0] rd;
    int m0;
    m0 = ram_cnt;
    access(0, 24'h00C030, 0, 5, "R8 io read", rd);
    chk("R8 io read data", 32'(rd), 32'h31);
    access(1, 24'h00C031, 8'h9E, 5, "R8 io write", rd);
    chk("R8 io write addr", 32'(io_last_addr), 32'hC031);
    chk("R8 io write data", 32'(io_last_data), 32'h9E);
    chk("R8 no ram enable", 32'(ram_cnt), 32'(m0));
  endtask

  task automatic t_cfg_block;
    @(negedge clk);
    cfg_we = 1; cfg_tbl = 2'd3; cfg_idx = 0; cfg_data = 0;
    req_valid = 1; req_write = 0; req_addr = 24'h000123;
    #1;
    chk("R9 ready low during config", 32'(req_ready), 0);
    @(posedge clk); #1;
    req_valid = 0; cfg_we = 0;
    @(negedge clk);
    chk("R9 nothing accepted", 32'(busy), 0);
  endtask

  task automatic t_backpressure;
    rsp_ready = 0;
    @(negedge clk);
    chk("R10 ready when idle", 32'(req_ready), 1);
    req_valid = 1; req_write = 0; req_addr = 24'h000123;
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk("R10 busy after accept", 32'(busy), 1);
    chk("R10 ready low while busy", 32'(req_ready), 0);
    @(negedge clk);
    chk("R11 response up", 32'(rsp_valid), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 valid held", 32'(rsp_valid), 1);
      chk("R11 data held", 32'(rsp_rdata), 32'hA7);
      chk("R10 still busy", 32'(busy), 1);
    end
    rsp_ready = 1;
    exp_pf = (exp_pf + 5) % 5;
    exp_ps = (exp_ps + 5) % 14;
    @(negedge clk);
    chk("R11 response taken", 32'(rsp_valid), 0);
    chk("R10 idle again", 32'(busy), 0);
  endtask

  task automatic t_phase;
    @(negedge clk);
    chk("R7 fast phase", 32'(phase_fast), 32'(exp_pf));
    chk("R7 slow phase", 32'(phase_slow), 32'(exp_ps));
  endtask

  initial begin
    t_reset();
    t_unmapped();
    t_configure();
    t_ram_basic();
    t_hole();
    t_rom();
    t_shadow();
    t_slow();
    t_io();
    t_cfg_block();
    t_backpressure();
    t_phase();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog R10 actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule